// File: doc/BRIEF.md
# Receive Message FIFO with Selectable Full Policy

This block is a circular queue for received frames. Each stored element is an identifier plus a payload word of fixed width. Frames come from an upstream acceptance stage over a valid/ready stream. The host drains them over a second valid/ready stream, where taking the head element counts as the read acknowledge that advances the get index. The block keeps put and get indices and a fill level, and shows all three as status. It also reports full, empty, a watermark and a sticky message-lost condition. The watermark and message-lost conditions each also have a single-cycle event pulse.

The depth is a parameter from 1 to 64 and need not be a power of two. A policy input chooses what happens when a frame arrives while the queue is full. With `cfg_overwrite` = 0 (blocking, the value a host drives out of reset) the frame is discarded. With `cfg_overwrite` = 1 the frame replaces the oldest stored element.

The write side has no back-pressure in the usual sense. `in_ready` only says whether a frame offered now will be stored. The source never holds a frame: a frame offered while `in_ready` is low is dropped. On the read side, `out_valid` is high while the queue holds anything. An element is consumed on a cycle where `out_valid` and `out_ready` are both high. `out_ready` while empty has no effect.

Top module: `rxf_fifo`

## Requirements
- R1: After reset the fill level, put index and get index are 0. `fifo_empty` is 1, `fifo_full` is 0, `out_valid` is 0, and `lost_flag`, `lost_pulse` and `wm_pulse` are 0.
- R2: Elements leave in arrival order. While the queue is not empty, `out_id`/`out_data` show the oldest stored element and `out_valid` is 1.
- R3: `fill_level` counts the stored elements and never exceeds DEPTH. `fifo_full` is 1 exactly when the level equals DEPTH, and `fifo_empty` is 1 exactly when the level is 0. `in_ready` is 0 only when the queue is full and `cfg_overwrite` is 0.
- R4: In blocking mode, a frame offered while full is discarded: the stored contents and the put index are unchanged. `lost_pulse` is 1 for the following cycle, and `lost_flag` becomes 1 and stays 1.
- R5: `lost_clear` = 1 for a cycle clears `lost_flag` at the next edge. If a frame is dropped in that same cycle, the flag stays 1.
- R6: In overwrite mode, a frame offered while full with no acknowledge in that cycle is stored at the put index. Both indices advance, so the oldest element is lost. The level stays DEPTH, and neither `lost_pulse` nor `lost_flag` is raised.
- R7: A cycle with both a stored frame and an accepted acknowledge leaves the level unchanged and advances both indices.
- R8: `out_ready` while the queue is empty changes neither the get index nor the level.
- R9: With `cfg_watermark` nonzero, `wm_hit` is 1 while level ≥ `cfg_watermark`. `wm_pulse` is 1 for one cycle after an edge where the level goes from below the watermark to at or above it. A watermark of 0 keeps both at 0.
- R10: The put and get indices count 0 to DEPTH-1 and wrap from DEPTH-1 to 0, also for a depth that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_overwrite | input | 1 | Full policy: 0 block, 1 overwrite oldest |
| cfg_watermark | input | LVL_W | Watermark level; 0 disables it |
| in_valid | input | 1 | A received frame is offered |
| in_ready | output | 1 | An offered frame will be stored |
| in_id | input | ID_W | Identifier of the offered frame |
| in_data | input | DATA_W | Payload word of the offered frame |
| out_valid | output | 1 | The head element is available |
| out_ready | input | 1 | Host takes the head element (read acknowledge) |
| out_id | output | ID_W | Identifier of the head element |
| out_data | output | DATA_W | Payload word of the head element |
| put_idx | output | IDX_W | Next write index |
| get_idx | output | IDX_W | Head read index |
| fill_level | output | LVL_W | Number of stored elements |
| fifo_full | output | 1 | Level equals DEPTH |
| fifo_empty | output | 1 | Level is 0 |
| lost_flag | output | 1 | Sticky: a frame was discarded |
| lost_clear | input | 1 | Write-one clear of lost_flag |
| lost_pulse | output | 1 | One-cycle event: a frame was discarded |
| wm_pulse | output | 1 | One-cycle event: level reached the watermark |
| wm_hit | output | 1 | Level is at or above a nonzero watermark |

## Verification
The bench runs a five-deep queue, so the indices wrap at a depth that is not a power of two. It sweeps both policies and every watermark value, including 0 and values above the depth. In each setting it overfills the queue by two frames, clears the lost flag, mixes writes with acknowledges while full, and drains past empty. An index that wrapped at the power of two would leave the head element pointing at a slot never written. Each of the following faults shows up as a wrong head element or a wrong level at the next sample:
- a blocking queue that still wrote when full;
- an overwrite that did not also advance the get index;
- an acknowledge that was honoured while empty.

A clear that beat a simultaneous drop, and a watermark pulse that fired on every cycle above the mark instead of on the crossing, each produce a wrong flag value at the cycle after the edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned MAX_DEPTH = 64;

  typedef enum logic {
    POL_BLOCK     = 1'b0,
    POL_OVERWRITE = 1'b1
  } full_policy_e;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH  = 8,
  parameter int ELEM_W = 61,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ELEM_W-1:0] wr_elem,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ELEM_W-1:0] rd_elem
);

  logic [ELEM_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) slot[g] <= wr_elem;
    end
  end

  always_comb begin
    rd_elem = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) rd_elem = slot[i];
    end
  end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             overwrite,
  input  logic             ack_req,
  output logic             wr_en,
  output logic [IDX_W-1:0] put_idx,
  output logic [IDX_W-1:0] get_idx,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_nxt,
  output logic             full,
  output logic             empty,
  output logic             drop
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DEPTH - 1);

  logic ack_en, evict, get_step;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
    if (i == IDX_TOP) return '0;
    return i + 1'b1;
  endfunction

  assign full     = (level == LVL_MAX);
  assign empty    = (level == '0);
  assign ack_en   = ack_req && !empty;
  assign wr_en    = wr_req && (!full || overwrite);
  assign drop     = wr_req && full && !overwrite;
  // Overwrite of the oldest slot: only when nothing was freed this cycle.
  assign evict    = wr_en && full && !ack_en;
  assign get_step = ack_en || evict;

  always_comb begin
    level_nxt = level;
    if (wr_en && !evict && !ack_en)      level_nxt = level + 1'b1;
    else if (ack_en && !wr_en)           level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      put_idx <= '0;
      get_idx <= '0;
      level   <= '0;
    end else begin
      if (wr_en)    put_idx <= bump(put_idx);
      if (get_step) get_idx <= bump(get_idx);
      level <= level_nxt;
    end
  end

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  input  logic             lost_clear,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] level_nxt,
  input  logic [LVL_W-1:0] watermark,
  output logic             lost_flag,
  output logic             lost_pulse,
  output logic             wm_pulse,
  output logic             wm_hit
);

  logic wm_on, wm_cross;

  assign wm_on    = (watermark != '0);
  assign wm_hit   = wm_on && (level >= watermark);
  assign wm_cross = wm_on && (level < watermark) && (level_nxt >= watermark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_flag  <= 1'b0;
      lost_pulse <= 1'b0;
      wm_pulse   <= 1'b0;
    end else begin
      lost_pulse <= drop;
      wm_pulse   <= wm_cross;
      if (drop)            lost_flag <= 1'b1;
      else if (lost_clear) lost_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo
  import rxf_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int ID_W   = 29,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_overwrite,
  input  logic [LVL_W-1:0]  cfg_watermark,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] out_data,
  output logic [IDX_W-1:0]  put_idx,
  output logic [IDX_W-1:0]  get_idx,
  output logic [LVL_W-1:0]  fill_level,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              lost_flag,
  input  logic              lost_clear,
  output logic              lost_pulse,
  output logic              wm_pulse,
  output logic              wm_hit
);

  localparam int ELEM_W = ID_W + DATA_W;

  full_policy_e      policy;
  logic              wr_en, drop;
  logic [LVL_W-1:0]  level_nxt;
  logic [ELEM_W-1:0] head;

  assign policy = full_policy_e'(cfg_overwrite);

  rxf_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (in_valid),
    .overwrite (policy == POL_OVERWRITE),
    .ack_req   (out_ready),
    .wr_en     (wr_en),
    .put_idx   (put_idx),
    .get_idx   (get_idx),
    .level     (fill_level),
    .level_nxt (level_nxt),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .drop      (drop)
  );

  rxf_store #(.DEPTH(DEPTH), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (put_idx),
    .wr_elem ({in_id, in_data}),
    .rd_idx  (get_idx),
    .rd_elem (head)
  );

  rxf_flags #(.LVL_W(LVL_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .drop       (drop),
    .lost_clear (lost_clear),
    .level      (fill_level),
    .level_nxt  (level_nxt),
    .watermark  (cfg_watermark),
    .lost_flag  (lost_flag),
    .lost_pulse (lost_pulse),
    .wm_pulse   (wm_pulse),
    .wm_hit     (wm_hit)
  );

  assign in_ready  = !fifo_full || (policy == POL_OVERWRITE);
  assign out_valid = !fifo_empty;
  assign out_id    = head[ELEM_W-1:DATA_W];
  assign out_data  = head[DATA_W-1:0];

endmodule

// File: rtl/rxf_fifo_chk.sv
module rxf_fifo_chk #(
  parameter  int DEPTH  = 8,
  parameter  int ID_W   = 29,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_overwrite,
  input logic [LVL_W-1:0] cfg_watermark,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] put_idx,
  input logic [IDX_W-1:0] get_idx,
  input logic [LVL_W-1:0] fill_level,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             lost_flag,
  input logic             lost_clear,
  input logic             lost_pulse,
  input logic             wm_pulse
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH));

  assert_level_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !fifo_full && !(out_valid && out_ready))
      |=> fill_level == LVL_W'($past(fill_level) + 1'b1));

  assert_block_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fifo_full && !cfg_overwrite && !out_ready)
      |=> ($stable(put_idx) && lost_flag && lost_pulse));

  assert_lost_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_clear && !(in_valid && !in_ready)) |=> !lost_flag);

  assert_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fifo_full && cfg_overwrite && !out_ready)
      |=> (fifo_full && !lost_pulse));

  assert_same_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready) |=> $stable(fill_level));

  assert_empty_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && out_ready && !in_valid) |=> ($stable(get_idx) && fifo_empty));

  assert_wm_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_watermark == '0) |=> !wm_pulse);

endmodule

bind rxf_fifo rxf_fifo_chk #(.DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rxf_fifo.sv
`timescale 1ns/1ps
module sim_rxf_fifo;

  localparam int D  = 5;
  localparam int IW = 11;
  localparam int DW = 16;
  localparam int XW = 3;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_overwrite = 1'b0;
  logic [LW-1:0] cfg_watermark = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [IW-1:0] in_id = '0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [IW-1:0] out_id;
  logic [DW-1:0] out_data;
  logic [XW-1:0] put_idx, get_idx;
  logic [LW-1:0] fill_level;
  logic          fifo_full, fifo_empty;
  logic          lost_flag, lost_pulse, wm_pulse, wm_hit;
  logic          lost_clear = 1'b0;

  always #2 clk = ~clk;

  rxf_fifo #(.DEPTH(D), .ID_W(IW), .DATA_W(DW)) u0 (.*);

  int n_chk = 0;
  int n_err = 0;

  // Reference state, derived from the requirements
  int m_lvl = 0, m_put = 0, m_get = 0;
  bit m_lost = 0, m_lostp = 0, m_wmp = 0;
  logic [IW+DW-1:0] m_mem [D];
  int seq = 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 fill_level", int'(fill_level), m_lvl);
    chk("R3 fifo_full", int'(fifo_full), int'(m_lvl == D));
    chk("R3 fifo_empty", int'(fifo_empty), int'(m_lvl == 0));
    chk("R3 in_ready", int'(in_ready), int'((m_lvl < D) || cfg_overwrite));
    chk("R10 put_idx", int'(put_idx), m_put);
    chk("R10 get_idx", int'(get_idx), m_get);
    chk("R2 out_valid", int'(out_valid), int'(m_lvl > 0));
    if (m_lvl > 0) chk("R2 head element", int'({out_id, out_data}), int'(m_mem[m_get]));
    chk("R4/R5 lost_flag", int'(lost_flag), int'(m_lost));
    chk("R4 lost_pulse", int'(lost_pulse), int'(m_lostp));
    chk("R9 wm_pulse", int'(wm_pulse), int'(m_wmp));
    chk("R9 wm_hit", int'(wm_hit), int'(cfg_watermark != 0 && m_lvl >= int'(cfg_watermark)));
  endtask

  // One cycle: drive at the falling edge, update the reference, sample 1 ns after the rising edge.
  task automatic step(input bit v, input bit ack, input bit clr);
    int old_lvl, wm;
    bit acc, ack_en, drop;
    @(negedge clk);
    in_valid   = v;
    out_ready  = ack;
    lost_clear = clr;
    in_id      = IW'(seq * 37);
    in_data    = DW'(seq * 911 + 5);
    wm      = int'(cfg_watermark);
    old_lvl = m_lvl;
    acc     = v && (m_lvl < D || cfg_overwrite);
    ack_en  = ack && m_lvl > 0;
    drop    = v && m_lvl == D && !cfg_overwrite;       // R4
    if (acc && m_lvl == D && !ack_en) begin            // R6 overwrite oldest
      m_mem[m_put] = {in_id, in_data};
      m_put = (m_put + 1) % D;
      m_get = (m_get + 1) % D;
    end else begin                                     // R7 / R8
      if (ack_en) begin m_get = (m_get + 1) % D; m_lvl--; end
      if (acc) begin m_mem[m_put] = {in_id, in_data}; m_put = (m_put + 1) % D; m_lvl++; end
    end
    if (clr) m_lost = 0;                               // R5
    if (drop) m_lost = 1;
    m_lostp = drop;
    m_wmp = (wm != 0) && old_lvl < wm && m_lvl >= wm;  // R9
    seq++;
    @(posedge clk);
    #1;
    compare_all();
    @(negedge clk);
    in_valid = 0; out_ready = 0; lost_clear = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 level", int'(fill_level), 0);
    chk("R1 empty", int'(fifo_empty), 1);
    chk("R1 full", int'(fifo_full), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 put_idx", int'(put_idx), 0);
    chk("R1 get_idx", int'(get_idx), 0);
    chk("R1 lost_flag", int'(lost_flag), 0);
    chk("R1 pulses", int'(lost_pulse | wm_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int ow = 0; ow < 2; ow++) begin
      for (int wm = 0; wm < 8; wm++) begin
        @(negedge clk);
        cfg_overwrite = ow[0];
        cfg_watermark = LW'(wm);
        for (int k = 0; k < D + 2; k++) step(1, 0, 0);   // overfill: R4 or R6
        step(1, 0, 1);                                    // R5 clear vs drop
        step(0, 0, 1);                                    // R5 plain clear
        for (int k = 0; k < 3; k++) step(1, 1, 0);        // R7 while full
        for (int k = 0; k < D + 2; k++) step(0, 1, 0);    // drain, R8 at the end
        step(1, 1, 0);                                    // ack on empty plus write
        for (int k = 0; k < 3; k++) step(1, 1, 0);        // R7 at level 1
        for (int k = 0; k < 3; k++) step(1, 0, 0);
        for (int k = 0; k < D + 1; k++) step(0, 1, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule